// File: doc/BRIEF.md
# Coded-register upset injector

This block owns a protected storage word of 13 bits: an 8-bit data field in bits 12..5 and a 5-bit check field in bits 4..0. It exists so that the error detection and correction logic around such a word can be tested. On command it flips chosen bits of the word, which models a single-event upset.

The flips come from a 4-bit linear feedback shift register. Its state is XORed into one 4-bit field of the word: the upper data nibble, the lower data nibble or the low nibble of the check field. A two-bit mode input picks one of three behaviours:

- **Normal:** the injector never touches the word.
- **Precision:** a chosen seed is flipped once, and the register then clears until a new seed is loaded.
- **Random:** the register walks its maximal-length sequence, so each injection applies a fresh pseudo-random pattern.

Injection instants come from a separate injection strobe that is not related to the system clock. That strobe is synchronised inside the block. The block gives one pulse for each injection and keeps a running count of injections, so that a test environment can compare the errors it detects with the upsets it caused.

Top module: `seu_inject_reg`

## Requirements
- R1: While `rst_n` is low the word reads 0, `inj_pulse_o` is 0 and `inj_count_o` is 0. The LFSR state reset value is 4'b0001.
- R2: With `ce_i` high at a clock edge and no injection at that edge, `word_o` becomes `{data_i, check_i}`. With `ce_i` low and no injection, `word_o` holds its value.
- R3: Mode codes 0 (normal) and 3 are inactive. In an inactive mode, injection strobe edges and `seed_load_i` have no effect: the word is never altered by the injector, no pulse appears, the count holds and the LFSR state does not change.
- R4: Each rising edge of `inj_clk_i` passes through a two-flop synchroniser and an edge detector. In an active mode the word is corrupted, and `inj_pulse_o` is high for exactly one cycle, on the third rising clock edge after the strobe rises. A strobe held high gives only one injection.
- R5: `target_i` selects the field that receives the 4-bit mask:
  - 0 selects bits 12..9 (upper data nibble).
  - 1 selects bits 8..5 (lower data nibble).
  - 2 selects bits 3..0 (check field).
  - 3 selects no field.

  Every bit outside the selected field is left unchanged.
- R6: In precision mode (code 1) an injection XORs the current LFSR state into the target field, and the LFSR then clears to 0. A further injection without a new seed flips nothing.
- R7: In random mode (code 2) an injection XORs the current state into the target field and advances the LFSR by the polynomial x^4+x^3+1, next = {s[2:0], s[3]^s[2]}. There is no clearing, so a nonzero seed cycles through all 15 nonzero states.
- R8: In an active mode, `seed_load_i` loads `seed_i` into the LFSR at the next clock edge. The number of set bits in the seed is the number of bits flipped, and a zero seed flips nothing.
- R9: When `ce_i` and an injection fall on the same edge, the mask is applied to the freshly loaded value `{data_i, check_i}`.
- R10: `inj_count_o` increments by one for every injection in an active mode, including injections whose mask is zero, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 normal, 1 precision, 2 random, 3 inactive |
| target_i | input | 2 | Field selection for the mask |
| ce_i | input | 1 | Write enable for the protected word |
| data_i | input | DATA_W (8) | Data field input |
| check_i | input | CHK_W (5) | Check bits from the external parity generator |
| seed_i | input | NIB_W (4) | Seed value for the LFSR |
| seed_load_i | input | 1 | Load `seed_i` into the LFSR |
| inj_clk_i | input | 1 | Asynchronous injection strobe |
| word_o | output | DATA_W+CHK_W (13) | Protected word |
| inj_pulse_o | output | 1 | One-cycle marker of each injection |
| inj_count_o | output | CNT_W (16) | Number of injections performed |

## Verification
A regular write and an injection can land on the same clock edge. In that case the flip must corrupt the newly written value, not the value that was stored before. The bench provokes this by raising `ce_i` in the cycle just before the third synchronised edge after the strobe rises, and it also leaves the overlap to chance during the random phase. A model in the bench predicts the word as the new data XORed with the placed mask, and every injection also checks the pulse and the count.

// File: rtl/fi_pkg.sv
package fi_pkg;

   typedef enum logic [1:0] {
      FI_MODE_OFF     = 2'd0,
      FI_MODE_PRECISE = 2'd1,
      FI_MODE_RANDOM  = 2'd2,
      FI_MODE_RSVD    = 2'd3
   } fi_mode_e;

   typedef enum logic [1:0] {
      FI_TGT_DATA_HI = 2'd0,
      FI_TGT_DATA_LO = 2'd1,
      FI_TGT_CHECK   = 2'd2,
      FI_TGT_NONE    = 2'd3
   } fi_target_e;

   localparam int FI_NUM_FIELDS = 3;

endpackage

// File: rtl/fi_sync_edge.sv
module fi_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES:0] chain_q;

   initial begin
      PRM_SYNC_DEPTH: assert (STAGES >= 2)
         else $error("fi_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o)
      else $error("rise held two cycles"); // R4

endmodule

// File: rtl/fi_lfsr.sv
module fi_lfsr #(
   parameter int           W          = 4,
   parameter logic [W-1:0] TAPS       = 4'b1100,
   parameter logic [W-1:0] RESET_SEED = 4'b0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] seed_i,
   input  logic         step_i,
   input  logic         clear_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic         fb;
   logic [W-1:0] adv;

   initial begin
      PRM_LFSR_WIDTH: assert (W >= 2)
         else $error("fi_lfsr: W must be at least 2");
      PRM_LFSR_TAPS: assert (TAPS[W-1] == 1'b1)
         else $error("fi_lfsr: top tap must be set");
   end

   assign fb  = ^(state_q & TAPS);
   assign adv = {state_q[W-2:0], fb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= RESET_SEED;
      else if (load_i)  state_q <= seed_i;
      else if (step_i)  state_q <= clear_i ? '0 : adv;
   end

   assign state_o = state_q;

   AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> state_q == $past(seed_i))
      else $error("seed not loaded"); // R8

   AST_PRECISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && clear_i && !load_i) |=> state_q == '0)
      else $error("state not cleared after precise injection"); // R6

   AST_RANDOM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clear_i && !load_i && state_q != '0) |=> state_q != '0)
      else $error("random walk reached zero"); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(state_q))
      else $error("state moved without command"); // R3

endmodule

// File: rtl/fi_mask_place.sv
module fi_mask_place
   import fi_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 5,
   parameter int NIB_W  = 4,
   localparam int WORD_W = DATA_W + CHK_W
) (
   input  logic [NIB_W-1:0]  nib_i,
   input  logic [1:0]        target_i,
   output logic [WORD_W-1:0] mask_o
);

   function automatic int field_ofs(input int f);
      case (f)
         0:       return CHK_W + DATA_W - NIB_W;
         1:       return CHK_W;
         default: return 0;
      endcase
   endfunction

   initial begin
      PRM_NIB_DATA: assert (2 * NIB_W <= DATA_W)
         else $error("fi_mask_place: data field too narrow");
      PRM_NIB_CHECK: assert (NIB_W <= CHK_W)
         else $error("fi_mask_place: check field too narrow");
   end

   logic [WORD_W-1:0] part [FI_NUM_FIELDS];
   logic [WORD_W-1:0] nib_ext;

   assign nib_ext = {{(WORD_W-NIB_W){1'b0}}, nib_i};

   for (genvar f = 0; f < FI_NUM_FIELDS; f++) begin : g_field
      localparam int OFS = field_ofs(f);
      assign part[f] = (target_i == 2'(f)) ? (nib_ext << OFS) : '0;
   end

   always_comb begin
      mask_o = '0;
      for (int f = 0; f < FI_NUM_FIELDS; f++) mask_o |= part[f];
   end

endmodule

// File: rtl/seu_inject_reg.sv
module seu_inject_reg
   import fi_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               CHK_W       = 5,
   parameter int               NIB_W       = 4,
   parameter logic [NIB_W-1:0] LFSR_TAPS   = 4'b1100,
   parameter logic [NIB_W-1:0] RESET_SEED  = 4'b0001,
   parameter int               SYNC_STAGES = 2,
   parameter int               CNT_W       = 16,
   localparam int              WORD_W      = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [1:0]        target_i,
   input  logic              ce_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  check_i,
   input  logic [NIB_W-1:0]  seed_i,
   input  logic              seed_load_i,
   input  logic              inj_clk_i,
   output logic [WORD_W-1:0] word_o,
   output logic              inj_pulse_o,
   output logic [CNT_W-1:0]  inj_count_o
);

   fi_mode_e          mode;
   logic              active;
   logic              inj_rise;
   logic              inj_fire;
   logic [NIB_W-1:0]  lfsr_state;
   logic [NIB_W-1:0]  mask_nib;
   logic [WORD_W-1:0] mask_word;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_d;
   logic              pulse_q;
   logic [CNT_W-1:0]  count_q;

   initial begin
      PRM_COUNT_WIDTH: assert (CNT_W >= 1)
         else $error("seu_inject_reg: CNT_W must be positive");
   end

   assign mode     = fi_mode_e'(mode_i);
   assign active   = (mode == FI_MODE_PRECISE) || (mode == FI_MODE_RANDOM);
   assign inj_fire = inj_rise & active;

   fi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (inj_clk_i),
      .rise_o  (inj_rise)
   );

   fi_lfsr #(.W(NIB_W), .TAPS(LFSR_TAPS), .RESET_SEED(RESET_SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (seed_load_i & active),
      .seed_i  (seed_i),
      .step_i  (inj_fire),
      .clear_i (mode == FI_MODE_PRECISE),
      .state_o (lfsr_state)
   );

   assign mask_nib = inj_fire ? lfsr_state : '0;

   fi_mask_place #(.DATA_W(DATA_W), .CHK_W(CHK_W), .NIB_W(NIB_W)) u_place (
      .nib_i    (mask_nib),
      .target_i (target_i),
      .mask_o   (mask_word)
   );

   assign word_d = (ce_i ? {data_i, check_i} : word_q) ^ mask_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         pulse_q <= 1'b0;
         count_q <= '0;
      end else begin
         word_q  <= word_d;
         pulse_q <= inj_fire;
         count_q <= count_q + CNT_W'(inj_fire);
      end
   end

   assign word_o      = word_q;
   assign inj_pulse_o = pulse_q;
   assign inj_count_o = count_q;

   AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !inj_pulse_o)
      else $error("pulse in inactive mode"); // R3

   AST_OFF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && ce_i) |=> word_o == $past({data_i, check_i}))
      else $error("word altered in inactive mode"); // R3

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_i && !inj_fire) |=> $stable(word_o))
      else $error("word changed without write or injection"); // R2

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse_o |=> !inj_pulse_o)
      else $error("pulse longer than one cycle"); // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse_o |-> inj_count_o == $past(inj_count_o) + CNT_W'(1))
      else $error("count did not step with pulse"); // R10

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_pulse_o |-> $stable(inj_count_o))
      else $error("count moved without pulse"); // R10

   AST_MASK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (target_i == FI_TGT_NONE) |-> mask_word == '0)
      else $error("mask outside any field"); // R5

endmodule

// File: tb/seu_inject_reg_tb_top.sv
module seu_inject_reg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic [1:0]  target_i = 2'd0;
   logic        ce_i = 1'b0;
   logic [7:0]  data_i = '0;
   logic [4:0]  check_i = '0;
   logic [3:0]  seed_i = '0;
   logic        seed_load_i = 1'b0;
   logic        inj_clk_i = 1'b0;
   logic [12:0] word_o;
   logic        inj_pulse_o;
   logic [15:0] inj_count_o;

   int checks = 0;
   int fails  = 0;

   logic [12:0] exp_word = '0;
   logic [3:0]  exp_lfsr = 4'b0001;
   logic [15:0] exp_cnt  = '0;

   always #5 clk = ~clk;

   seu_inject_reg dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .target_i(target_i),
      .ce_i(ce_i), .data_i(data_i), .check_i(check_i), .seed_i(seed_i),
      .seed_load_i(seed_load_i), .inj_clk_i(inj_clk_i), .word_o(word_o),
      .inj_pulse_o(inj_pulse_o), .inj_count_o(inj_count_o)
   );

   function automatic logic [3:0] lfsr_next(input logic [3:0] s);
      return {s[2:0], s[3] ^ s[2]};
   endfunction

   function automatic logic [12:0] place(input logic [1:0] t, input logic [3:0] n);
      case (t)
         2'd0:    return {n, 9'b0};
         2'd1:    return {4'b0, n, 5'b0};
         2'd2:    return {9'b0, n};
         default: return 13'b0;
      endcase
   endfunction

   function automatic bit is_active(input logic [1:0] m);
      return (m == 2'd1) || (m == 2'd2);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_load(input logic [7:0] d, input logic [4:0] c);
      @(negedge clk);
      ce_i = 1'b1; data_i = d; check_i = c;
      @(negedge clk);
      ce_i = 1'b0;
      exp_word = {d, c};
      check("R2 load", 32'(word_o), 32'(exp_word));
   endtask

   task automatic do_seed(input logic [3:0] s);
      @(negedge clk);
      seed_i = s; seed_load_i = 1'b1;
      @(negedge clk);
      seed_load_i = 1'b0;
      if (is_active(mode_i)) exp_lfsr = s;
   endtask

   // Strobe rises at a falling edge; effect lands on the third rising edge.
   task automatic do_inject(input bit with_load, input logic [7:0] d,
                            input logic [4:0] c, input int hold, input string tag);
      logic [12:0] base;
      logic [12:0] m;
      @(negedge clk);
      inj_clk_i = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      if (with_load) begin ce_i = 1'b1; data_i = d; check_i = c; end
      @(posedge clk);
      @(negedge clk);
      ce_i = 1'b0;
      base = with_load ? {d, c} : exp_word;
      m = '0;
      if (is_active(mode_i)) begin
         m = place(target_i, exp_lfsr);
         exp_lfsr = (mode_i == 2'd1) ? 4'b0 : lfsr_next(exp_lfsr);
         exp_cnt++;
      end
      exp_word = base ^ m;
      check({tag, " word"}, 32'(word_o), 32'(exp_word));
      check({tag, " pulse R4"}, 32'(inj_pulse_o), 32'(is_active(mode_i)));
      check({tag, " count R10"}, 32'(inj_count_o), 32'(exp_cnt));
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check({tag, " R4 held strobe no repeat"}, 32'(inj_pulse_o), 32'd0);
      end
      inj_clk_i = 1'b0;
      @(negedge clk);
      check({tag, " R4 pulse width"}, 32'(inj_pulse_o), 32'd0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 word", 32'(word_o), 32'd0);
      check("R1 pulse", 32'(inj_pulse_o), 32'd0);
      check("R1 count", 32'(inj_count_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: load and hold
      do_load(8'hA5, 5'h13);
      repeat (2) @(negedge clk);
      check("R2 hold", 32'(word_o), 32'(exp_word));

      // R3: inactive modes ignore strobe and seed loads
      mode_i = 2'd0;
      do_inject(1'b0, '0, '0, 0, "R3 mode0");
      mode_i = 2'd3;
      do_inject(1'b0, '0, '0, 0, "R3 mode3");
      do_seed(4'b1111);
      mode_i = 2'd1; target_i = 2'd1;
      // reset seed 0001 must still be in place (R1, R3)
      do_inject(1'b0, '0, '0, 0, "R3 seed ignored R6 R5 lo");
      // R6: cleared after use, second shot flips nothing but counts
      do_inject(1'b0, '0, '0, 0, "R6 cleared R10");

      // R8, R5: precision seed into check field
      do_seed(4'b1011);
      target_i = 2'd2;
      do_inject(1'b0, '0, '0, 0, "R8 R5 check field");
      do_seed(4'b0000);
      target_i = 2'd0;
      do_inject(1'b0, '0, '0, 0, "R8 zero seed");
      do_seed(4'b1111);
      target_i = 2'd3;
      do_inject(1'b0, '0, '0, 0, "R5 no field");

      // R7: random walk over the upper nibble
      mode_i = 2'd2; target_i = 2'd0;
      do_seed(4'b0001);
      for (int k = 0; k < 6; k++) do_inject(1'b0, '0, '0, 0, "R7 walk");

      // R9: write and injection on the same edge
      target_i = 2'd1;
      do_inject(1'b1, 8'h3C, 5'h0A, 0, "R9 overlap");
      mode_i = 2'd1; do_seed(4'b0110); target_i = 2'd2;
      do_inject(1'b1, 8'hF0, 5'h1F, 0, "R9 overlap precise");

      // R4: strobe held high gives a single injection
      mode_i = 2'd2; target_i = 2'd0; do_seed(4'b1001);
      do_inject(1'b0, '0, '0, 6, "R4 long strobe");

      // constrained random phase
      for (int it = 0; it < 120; it++) begin
         int act;
         act = $urandom_range(0, 3);
         case (act)
            0: do_load(8'($urandom), 5'($urandom));
            1: do_seed(4'($urandom));
            2: do_inject(1'($urandom), 8'($urandom), 5'($urandom), 0, "R5 R6 R7 R9 random");
            default: begin
               @(negedge clk);
               mode_i = 2'($urandom);
               target_i = 2'($urandom);
            end
         endcase
      end
      @(negedge clk);
      check("R10 final count", 32'(inj_count_o), 32'(exp_cnt));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule